// File: doc/BRIEF.md
# Split-Carry Phase Accumulator

This block is the phase register of a numerically controlled oscillator. On every enabled clock it adds an increment word to a running phase, modulo 2^PHASE_W. The adder is split into two halves of equal width so that no carry ripples across the whole word in one cycle. The low half accumulates the low bits of the increment. Its carry-out is captured in a flop and enters the high half on the next clock.

The high half of the increment passes through one register, so it reaches the high adder in the same cycle as the carry that belongs with it. The low-half sum also goes through one register before it reaches the output, but the low half's own feedback uses the undelayed sum. The phase word at the output is therefore exact: it is the full-width modular sum of the same increments, one enabled clock later. A clock enable freezes both halves, the carry flop and both alignment registers together. The reset is asynchronous, and the output can drive a phase-to-amplitude stage directly.

Top module: `phase_acc_split`

## Requirements
- R1: Driving rst_ni low clears phase_o to zero at once, without waiting for a clock edge, and phase_o stays zero while rst_ni is low.
- R2: After n enabled clock edges since reset, phase_o equals the sum modulo 2^PHASE_W of the increments sampled at the first n-1 of those edges. That is a plain accumulation with one enabled edge of latency.
- R3: Between two consecutive enabled edges, phase_o advances by exactly the increment sampled one enabled edge earlier, even when incr_i changes on every clock. The output never mixes old and new increment halves.
- R4: A carry out of the low half (bit PHASE_W/2 - 1 into bit PHASE_W/2) appears in the upper half of phase_o in the same output word as the low-half sum that produced it.
- R5: The accumulation wraps modulo 2^PHASE_W, and a carry out of the top bit is dropped.
- R6: While en_i is low, phase_o and all internal state hold, and incr_i is ignored. When en_i returns high, accumulation resumes as if the disabled cycles had not occurred.
- R7: A reset in the middle of a run restarts the accumulation from zero. No carry or delayed increment survives it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Clock enable for all state |
| incr_i | input | PHASE_W | Phase increment (tuning word) |
| phase_o | output | PHASE_W | Accumulated phase word |

## Verification
Small increments show the basic one-edge latency. Increments of 0x0000_FFFF and 0x0000_8000 force a carry out of the low half on chosen edges, which separates a correctly aligned carry from one that lands a cycle early or late. Increments that change on every clock, with differing upper halves, expose any mismatch in when the upper addend is delayed. Large words such as 0xC000_0000 and 0xFFFF_FFFF exercise modular wrap. Gaps in en_i with a changing incr_i, and a reset in mid-run, separate state that truly holds or clears from state that leaks through.

// File: rtl/phase_acc_pkg.sv
package phase_acc_pkg;
  function automatic int lo_width(int total_w);
    return total_w / 2;
  endfunction

  function automatic int hi_width(int total_w);
    return total_w - (total_w / 2);
  endfunction
endpackage

// File: rtl/phase_acc_lo_seg.sv
module phase_acc_lo_seg #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] incr_i,
  output logic [W-1:0] acc_o,
  output logic         carry_o
);
  logic [W:0]   sum;
  logic [W-1:0] acc_q;
  logic         carry_q;

  // single adder level between acc_q and its own input
  assign sum = {1'b0, acc_q} + {1'b0, incr_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q   <= '0;
      carry_q <= 1'b0;
    end else if (en_i) begin
      acc_q   <= sum[W-1:0];
      carry_q <= sum[W];
    end
  end

  assign acc_o   = acc_q;
  assign carry_o = carry_q;
endmodule

// File: rtl/phase_acc_hi_seg.sv
module phase_acc_hi_seg #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] incr_i,
  input  logic         carry_i,
  output logic [W-1:0] acc_o
);
  logic [W-1:0] incr_q;
  logic [W-1:0] acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      incr_q <= '0;
      acc_q  <= '0;
    end else if (en_i) begin
      incr_q <= incr_i;  // aligns with registered carry from the low half
      acc_q  <= acc_q + incr_q + {{(W-1){1'b0}}, carry_i};
    end
  end

  assign acc_o = acc_q;
endmodule

// File: rtl/phase_acc_dly.sv
module phase_acc_dly #(
  parameter int W     = 16,
  parameter int DEPTH = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage [DEPTH+1];

  assign stage[0] = d_i;

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   stage[g+1] <= '0;
      else if (en_i) stage[g+1] <= stage[g];
    end
  end

  assign q_o = stage[DEPTH];
endmodule

// File: rtl/phase_acc_split.sv
module phase_acc_split
  import phase_acc_pkg::*;
#(
  parameter int PHASE_W = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic [PHASE_W-1:0] incr_i,
  output logic [PHASE_W-1:0] phase_o
);
  localparam int LO_W = lo_width(PHASE_W);
  localparam int HI_W = hi_width(PHASE_W);

  logic [LO_W-1:0] lo_acc;
  logic [LO_W-1:0] lo_out;
  logic [HI_W-1:0] hi_acc;
  logic            lo_carry;

  phase_acc_lo_seg #(.W(LO_W)) i_lo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .incr_i  (incr_i[LO_W-1:0]),
    .acc_o   (lo_acc),
    .carry_o (lo_carry)
  );

  phase_acc_hi_seg #(.W(HI_W)) i_hi (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .incr_i  (incr_i[PHASE_W-1:LO_W]),
    .carry_i (lo_carry),
    .acc_o   (hi_acc)
  );

  // output-only delay; low feedback stays undelayed inside i_lo
  phase_acc_dly #(.W(LO_W), .DEPTH(1)) i_lo_dly (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .d_i    (lo_acc),
    .q_o    (lo_out)
  );

  assign phase_o = {hi_acc, lo_out};
endmodule

// File: rtl/phase_acc_split_chk.sv
module phase_acc_split_chk #(
  parameter int PHASE_W = 32,
  parameter int LO_W    = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               en_i,
  input logic [PHASE_W-1:0] incr_i,
  input logic [PHASE_W-1:0] phase_o,
  input logic [LO_W-1:0]    lo_acc_i
);
  logic [1:0] since_rst;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  // R1
  reset_zero_chk: assert property (@(posedge clk_i) !rst_ni |-> phase_o == '0);

  // R3
  step_exact_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst >= 2'd2 && $past(en_i) && $past(en_i, 2))
      |-> phase_o == $past(phase_o) + $past(incr_i, 2));

  // R6
  hold_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(phase_o));

  // R6
  hold_lo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(lo_acc_i));
endmodule

bind phase_acc_split phase_acc_split_chk #(.PHASE_W(PHASE_W), .LO_W(LO_W)) i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .en_i     (en_i),
  .incr_i   (incr_i),
  .phase_o  (phase_o),
  .lo_acc_i (lo_acc)
);

// File: tb/test_phase_acc_split.sv
module test_phase_acc_split;
  localparam int PHASE_W = 32;
  localparam int NVEC    = 16;

  localparam logic [PHASE_W-1:0] VEC_INC [NVEC] = '{
    32'h0000_0001, 32'h0000_0003, 32'h0000_FFFF, 32'h0000_FFFF,
    32'h0001_0000, 32'h8000_0001, 32'h1234_5678, 32'h0000_0000,
    32'hFFFF_FFFF, 32'h0000_8001, 32'h7FFF_8000, 32'hDEAD_BEEF,
    32'h0000_0000, 32'h0001_FFFF, 32'hFFFE_0001, 32'h0000_0010
  };
  localparam bit VEC_EN [NVEC] = '{
    1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1,
    1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1
  };

  logic               clk = 1'b0;
  logic               rst_ni = 1'b0;
  logic               en_i = 1'b0;
  logic [PHASE_W-1:0] incr_i = '0;
  logic [PHASE_W-1:0] phase_o;

  int n_checks = 0;
  int n_errs   = 0;
  bit done     = 1'b0;

  logic [PHASE_W-1:0] ref_acc = '0;
  logic [PHASE_W-1:0] ref_out = '0;

  always #2 clk = ~clk;

  phase_acc_split #(.PHASE_W(PHASE_W)) i_phase_acc_split (
    .clk_i   (clk),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .incr_i  (incr_i),
    .phase_o (phase_o)
  );

  task automatic check(string tag, logic [PHASE_W-1:0] exp);
    n_checks++;
    if (phase_o !== exp) begin
      n_errs++;
      $display("FAIL %s: phase_o=%h expected=%h", tag, phase_o, exp);
    end
  endtask

  // drive at negedge, model the edge, sample at next negedge
  task automatic step(string tag, logic [PHASE_W-1:0] inc, bit en);
    incr_i = inc;
    en_i   = en;
    @(posedge clk);
    if (en) begin
      ref_out = ref_acc;
      ref_acc = ref_acc + inc;
    end
    @(negedge clk);
    check(tag, ref_out);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    en_i   = 1'b0;
    ref_acc = '0;
    ref_out = '0;
    @(negedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_errs++;
      n_checks++;
      $display("FAIL watchdog: phase_o=%h expected=completion", phase_o);
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    check("R1 reset state", '0);
    rst_ni = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      step("R2 table", VEC_INC[i], VEC_EN[i]);
    end

    // R4: carry from low half lands with its low sum
    do_reset();
    for (int i = 0; i < 6; i++) step("R4 carry", 32'h0000_8000, 1'b1);
    step("R4 carry", 32'h0000_FFFF, 1'b1);
    step("R4 carry", 32'h0000_0001, 1'b1);
    step("R4 carry", 32'h0000_0000, 1'b1);

    // R3: increment changes every edge, differing halves
    do_reset();
    for (int i = 0; i < 10; i++)
      step("R3 change", (i % 2 == 0) ? 32'h0001_FFFF : 32'h7FFF_0001, 1'b1);

    // R5: modular wrap
    do_reset();
    for (int i = 0; i < 7; i++) step("R5 wrap", 32'hC000_0000, 1'b1);
    step("R5 wrap", 32'hFFFF_FFFF, 1'b1);
    step("R5 wrap", 32'hFFFF_FFFF, 1'b1);
    step("R5 wrap", 32'h0000_0000, 1'b1);

    // R6: enable low holds everything, incr ignored
    do_reset();
    step("R6 hold", 32'h0000_FFFF, 1'b1);
    step("R6 hold", 32'h0000_0001, 1'b1);
    for (int i = 0; i < 5; i++) step("R6 hold", 32'hFFFF_0000 + i, 1'b0);
    step("R6 hold", 32'h0001_0002, 1'b1);
    step("R6 hold", 32'h0000_0000, 1'b1);
    step("R6 hold", 32'h0000_0000, 1'b1);

    // R7: reset mid-run, async clear then clean restart
    step("R7 prerun", 32'h0000_FFFF, 1'b1);
    step("R7 prerun", 32'h0001_FFFF, 1'b1);
    #1 rst_ni = 1'b0;
    #0.5;
    check("R1 async clear", '0);
    ref_acc = '0;
    ref_out = '0;
    en_i = 1'b0;
    @(negedge clk);
    check("R7 held in reset", '0);
    rst_ni = 1'b1;
    step("R7 restart", 32'h0000_0005, 1'b1);
    step("R7 restart", 32'h0000_0005, 1'b1);
    step("R7 restart", 32'h0000_0000, 1'b1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end
endmodule